// File: doc/BRIEF.md
# Event Timer Register File and Main Counter

This block is the software-facing core of a multi-channel event timer. It holds a 64-bit free-running tick counter, a fixed capability word, a two-bit global control register and a status word, and it decodes a 1 KB window of 32-bit register accesses. Accesses that land in the per-channel area are forwarded to the addressed channel through a one-hot select, a word offset and read/write strobes. The channel returns its read data on a shared vector.

The tick counter advances by one every clock while the global run bit is set. It freezes when that bit is cleared and resumes from the frozen value when the bit is set again. Software may load either 32-bit half at any time. A load while running is honoured but flagged as a software fault. When the run bit goes from 0 to 1, every channel whose comparator is not at its all-ones value receives a one-cycle re-arm pulse. The run and legacy-route bits are exported to the interrupt router.

Top module: `evt_regfile`

## Requirements
- R1: After reset, `count` is 0, both global control bits are 0, `rd_data` is 0 and no strobe or pulse output is active.
- R2: While the run bit (global control bit 0) is 1, `count` rises by exactly one per clock. While it is 0, `count` holds. Setting the bit again resumes counting from the held value.
- R3: A write to offset 0x0F0 replaces counter bits 31:0, and a write to 0x0F4 replaces bits 63:32. The other half is kept, and the written value wins over the increment in that cycle.
- R4: A counter-half write made while the run bit is 1 raises `cnt_wr_err` for exactly one cycle, starting the cycle after the write.
- R5: Offset 0x000 reads the capability word. For three channels this is 0x8086A201: revision in bits 7:0, channel count minus one in bits 12:8, 64-bit counter in bit 13 and legacy-route capability in bit 15. Offset 0x004 reads the tick period in femtoseconds, which is 10,000,000. Writes to both offsets are ignored.
- R6: Offset 0x010 stores only bits 1:0 of a write (bit 0 = run, bit 1 = legacy route) and reads them back with bits 31:2 at zero. Offsets 0x014 and 0x020 read 0, and writes to them change nothing.
- R7: Read data appears on `rd_data` on the clock after the read request and holds until the next read. Reads of 0x0F0 and 0x0F4 return the counter value present in the request cycle, each half independently.
- R8: An access to 0x100 + 32·n + 4·k, with n below the channel count, asserts `ch_sel` bit n only, drives `ch_offs` = k, and asserts `ch_wr` or `ch_rd` in the same cycle. A read returns the n-th 32-bit slice of `ch_rdata`.
- R9: Channel indices at or above the channel count, and unmapped global offsets, raise no channel strobe and read 0.
- R10: On a write that takes the run bit from 0 to 1, `ch_arm` bit n pulses for one cycle, the cycle after the write, for every channel whose `ch_cmp_max` bit is 0.
- R11: `glb_en` and `glb_legacy` show control bits 0 and 1 from the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address inside the window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| count | output | 64 | Main tick counter |
| glb_en | output | 1 | Global run bit |
| glb_legacy | output | 1 | Legacy-route bit |
| cnt_wr_err | output | 1 | Pulse: counter written while running |
| ch_sel | output | 3 | One-hot channel select |
| ch_wr | output | 1 | Channel write strobe |
| ch_rd | output | 1 | Channel read strobe |
| ch_offs | output | 3 | Word offset inside the channel stride |
| ch_wdata | output | 32 | Write data to the channel |
| ch_rdata | input | 96 | Read data from each channel, channel 0 in the low word |
| ch_cmp_max | input | 3 | Channel comparator is all ones |
| ch_arm | output | 3 | Re-arm pulse on run start |

## Verification
The hardest state to reach is a carry from the low half of the counter into the high half. The counter only gets there through a load, so the stimulus loads 0xFFFFFFFE into the low half, starts the counter and reads the high half a few cycles later. Re-arm pulses need a 0-to-1 run transition with a mixed `ch_cmp_max` pattern, so directed writes stop and restart the counter under chosen patterns. A seeded random mix of accesses over the mapped, unmapped and out-of-range addresses then exercises counter loads while running and reads landing on a freshly loaded half.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned OFF_CAPLO  = 'h000;
  localparam int unsigned OFF_PERIOD = 'h004;
  localparam int unsigned OFF_CFG    = 'h010;
  localparam int unsigned OFF_STAT   = 'h020;
  localparam int unsigned OFF_CNTLO  = 'h0F0;
  localparam int unsigned OFF_CNTHI  = 'h0F4;

  typedef enum logic [3:0] {
    RG_CAPLO,
    RG_PERIOD,
    RG_CFG,
    RG_STAT,
    RG_CNTLO,
    RG_CNTHI,
    RG_CHAN,
    RG_NONE
  } region_e;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         ld_lo,
  input  logic         ld_hi,
  input  logic [31:0]  ld_data,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (ld_lo)      q_d = {q[W-1:32], ld_data};
    else if (ld_hi) q_d = {ld_data, q[31:0]};
    else if (run)   q_d = q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   q <= '0;
    else if (ld_lo || ld_hi || run) q <= q_d;
  end
endmodule

// File: rtl/evt_decode.sv
module evt_decode
  import evt_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int NUM_CH  = 3,
  parameter int CH_BASE = 'h100,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SLOT_W = ADDR_W - 5
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [CH_W-1:0]   ch_idx,
  output logic [2:0]        ch_offs
);
  logic [SLOT_W-1:0] slot;
  logic [ADDR_W-1:0] waddr;

  assign waddr   = {addr[ADDR_W-1:2], 2'b00};
  assign slot    = addr[ADDR_W-1:5] - SLOT_W'(CH_BASE >> 5);
  assign ch_idx  = slot[CH_W-1:0];
  assign ch_offs = addr[4:2];

  always_comb begin
    region = RG_NONE;
    if (waddr >= ADDR_W'(CH_BASE)) begin
      if (slot < SLOT_W'(NUM_CH)) region = RG_CHAN;
    end else begin
      case (waddr)
        ADDR_W'(OFF_CAPLO):  region = RG_CAPLO;
        ADDR_W'(OFF_PERIOD): region = RG_PERIOD;
        ADDR_W'(OFF_CFG):    region = RG_CFG;
        ADDR_W'(OFF_STAT):   region = RG_STAT;
        ADDR_W'(OFF_CNTLO):  region = RG_CNTLO;
        ADDR_W'(OFF_CNTHI):  region = RG_CNTHI;
        default:             region = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/evt_rdmux.sv
module evt_rdmux
  import evt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter logic [15:0] VENDOR = 16'h8086,
  parameter logic [31:0] TICK_FS = 32'd10_000_000,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  region_e              region,
  input  logic [CH_W-1:0]      ch_idx,
  input  logic [1:0]           cfg,
  input  logic [63:0]          cnt,
  input  logic [NUM_CH*32-1:0] ch_rdata,
  output logic [31:0]          data
);
  localparam logic [31:0] CAP_WORD =
    {VENDOR, 1'b1, 1'b0, 1'b1, 5'(NUM_CH - 1), 8'h01};

  logic [31:0] ch_word;

  always_comb begin
    ch_word = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_idx == CH_W'(i)) ch_word = ch_rdata[i*32 +: 32];
    end
  end

  always_comb begin
    case (region)
      RG_CAPLO:  data = CAP_WORD;
      RG_PERIOD: data = TICK_FS;
      RG_CFG:    data = {30'd0, cfg};
      RG_CNTLO:  data = cnt[31:0];
      RG_CNTHI:  data = cnt[63:32];
      RG_CHAN:   data = ch_word;
      default:   data = '0;
    endcase
  end
endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
  import evt_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int NUM_CH  = 3,
  parameter int CH_BASE = 'h100,
  parameter logic [15:0] VENDOR  = 16'h8086,
  parameter logic [31:0] TICK_FS = 32'd10_000_000,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic [31:0]          rd_data,
  output logic [63:0]          count,
  output logic                 glb_en,
  output logic                 glb_legacy,
  output logic                 cnt_wr_err,
  output logic [NUM_CH-1:0]    ch_sel,
  output logic                 ch_wr,
  output logic                 ch_rd,
  output logic [2:0]           ch_offs,
  output logic [31:0]          ch_wdata,
  input  logic [NUM_CH*32-1:0] ch_rdata,
  input  logic [NUM_CH-1:0]    ch_cmp_max,
  output logic [NUM_CH-1:0]    ch_arm
);
  region_e         region;
  logic [CH_W-1:0] ch_idx;
  logic [31:0]     rd_mux;
  logic [1:0]      cfg_q, cfg_d;
  logic [31:0]     rd_q, rd_d;
  logic [NUM_CH-1:0] arm_q, arm_d;
  logic            err_q, err_d;
  logic            wr_req, rd_req, cfg_wr, ld_lo, ld_hi, cnt_ld, ch_hit;

  evt_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_BASE(CH_BASE)) u_dec (
    .addr(req_addr), .region(region), .ch_idx(ch_idx), .ch_offs(ch_offs)
  );

  evt_counter #(.W(64)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(cfg_q[0]), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .ld_data(req_wdata), .q(count)
  );

  evt_rdmux #(.NUM_CH(NUM_CH), .VENDOR(VENDOR), .TICK_FS(TICK_FS)) u_rmx (
    .region(region), .ch_idx(ch_idx), .cfg(cfg_q), .cnt(count),
    .ch_rdata(ch_rdata), .data(rd_mux)
  );

  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;
  assign cfg_wr = wr_req && (region == RG_CFG);
  assign ld_lo  = wr_req && (region == RG_CNTLO);
  assign ld_hi  = wr_req && (region == RG_CNTHI);
  assign cnt_ld = ld_lo || ld_hi;
  assign ch_hit = req_valid && (region == RG_CHAN);

  assign ch_wr    = ch_hit && req_write;
  assign ch_rd    = ch_hit && !req_write;
  assign ch_wdata = req_wdata;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign ch_sel[g] = ch_hit && (ch_idx == CH_W'(g));
  end

  always_comb begin
    cfg_d = cfg_wr ? req_wdata[1:0] : cfg_q;
    rd_d  = rd_req ? rd_mux : rd_q;
    err_d = cnt_ld && cfg_q[0];
    arm_d = (cfg_wr && req_wdata[0] && !cfg_q[0]) ? ~ch_cmp_max : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rd_q  <= '0;
      err_q <= 1'b0;
      arm_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      rd_q  <= rd_d;
      err_q <= err_d;
      arm_q <= arm_d;
    end
  end

  assign rd_data    = rd_q;
  assign glb_en     = cfg_q[0];
  assign glb_legacy = cfg_q[1];
  assign cnt_wr_err = err_q;
  assign ch_arm     = arm_q;

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !cnt_ld) |=> $stable(count));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && !cnt_ld) |=> (count == $past(count) + 64'd1));
  // R4
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_err |-> $past(glb_en));
  // R10
  arm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_arm) |-> $rose(glb_en));
  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel));
  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && region == RG_NONE) |=> (rd_data == 32'd0));
endmodule

// File: tb/evt_regfile_test.sv
module evt_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [9:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rd_data;
  logic [63:0] count;
  logic        glb_en, glb_legacy, cnt_wr_err;
  logic [NCH-1:0] ch_sel, ch_cmp_max, ch_arm;
  logic        ch_wr, ch_rd;
  logic [2:0]  ch_offs;
  logic [31:0] ch_wdata;
  logic [NCH*32-1:0] ch_rdata;

  int total_cnt = 0;
  int fail_cnt  = 0;

  logic [63:0] m_cnt;
  logic [1:0]  m_cfg;

  evt_regfile uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .count(count), .glb_en(glb_en), .glb_legacy(glb_legacy),
    .cnt_wr_err(cnt_wr_err), .ch_sel(ch_sel), .ch_wr(ch_wr), .ch_rd(ch_rd),
    .ch_offs(ch_offs), .ch_wdata(ch_wdata), .ch_rdata(ch_rdata),
    .ch_cmp_max(ch_cmp_max), .ch_arm(ch_arm)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_resp
    assign ch_rdata[g*32 +: 32] = 32'hA000_0000 | (32'(g) << 8) | 32'(ch_offs);
  end

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total_cnt++; fail_cnt++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [9:0] a);
    logic [9:0] w;
    w = {a[9:2], 2'b00};
    if (w >= 10'h100) begin
      if (((w - 10'h100) >> 5) < NCH)
        return 32'hA000_0000 | (32'((w - 10'h100) >> 5) << 8) | 32'(a[4:2]);
      return 32'd0;
    end
    case (w)
      10'h000: return 32'h8086A201;
      10'h004: return 32'd10_000_000;
      10'h010: return {30'd0, m_cfg};
      10'h0F0: return m_cnt[31:0];
      10'h0F4: return m_cnt[63:32];
      default: return 32'd0;
    endcase
  endfunction

  // one access; entered and left at a falling edge
  task automatic op(bit wr, logic [9:0] a, logic [31:0] d, logic [NCH-1:0] cm);
    logic [9:0]  w;
    logic        hit;
    logic [NCH-1:0] e_sel, e_arm;
    logic [31:0] e_rd;
    logic        e_err;
    w = {a[9:2], 2'b00};
    hit = (w >= 10'h100) && (((w - 10'h100) >> 5) < NCH);
    e_sel = hit ? NCH'(1 << ((w - 10'h100) >> 5)) : '0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; ch_cmp_max = cm;
    #1;
    chk(hit ? "R8 sel" : "R9 sel", 64'(ch_sel), 64'(e_sel));
    chk(hit ? "R8 wr" : "R9 wr", 64'(ch_wr), 64'(hit && wr));
    chk(hit ? "R8 rd" : "R9 rd", 64'(ch_rd), 64'(hit && !wr));
    if (hit) begin
      chk("R8 offs", 64'(ch_offs), 64'(a[4:2]));
      if (wr) chk("R8 wdata", 64'(ch_wdata), 64'(d));
    end
    e_rd  = exp_read(a);
    e_err = wr && (w == 10'h0F0 || w == 10'h0F4) && m_cfg[0];
    e_arm = (wr && w == 10'h010 && d[0] && !m_cfg[0]) ? ~cm : '0;
    if (wr && w == 10'h0F0)      m_cnt = {m_cnt[63:32], d};
    else if (wr && w == 10'h0F4) m_cnt = {d, m_cnt[31:0]};
    else if (m_cfg[0])           m_cnt = m_cnt + 64'd1;
    if (wr && w == 10'h010) m_cfg = d[1:0];
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) chk("R7 rd_data", 64'(rd_data), 64'(e_rd));
    chk("R3 count", count, m_cnt);
    chk("R11 en", 64'(glb_en), 64'(m_cfg[0]));
    chk("R11 legacy", 64'(glb_legacy), 64'(m_cfg[1]));
    chk("R4 err", 64'(cnt_wr_err), 64'(e_err));
    chk("R10 arm", 64'(ch_arm), 64'(e_arm));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (m_cfg[0]) m_cnt = m_cnt + 64'd1;
      chk("R2 count", count, m_cnt);
      chk("R10 arm idle", 64'(ch_arm), 64'd0);
    end
  endtask

  initial begin
    logic [9:0] pick [0:11];
    void'($urandom(32'd1234));
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; ch_cmp_max = '0;
    m_cnt = '0; m_cfg = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 64'd0);
    chk("R1 en", 64'(glb_en), 64'd0);
    chk("R1 legacy", 64'(glb_legacy), 64'd0);
    chk("R1 rd", 64'(rd_data), 64'd0);
    chk("R1 arm", 64'(ch_arm), 64'd0);
    chk("R1 err", 64'(cnt_wr_err), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    idle(2);  // R2 disabled: holds
    // R5 capability and period, writes ignored
    op(0, 10'h000, 0, '0);
    op(1, 10'h000, 32'hFFFF_FFFF, '0);
    op(1, 10'h004, 32'h1234_5678, '0);
    op(0, 10'h000, 0, '0);
    op(0, 10'h004, 0, '0);
    // R6 config bits, upper word and status
    op(1, 10'h010, 32'hFFFF_FFFE, '0);
    op(0, 10'h010, 0, '0);
    op(1, 10'h014, 32'hFFFF_FFFF, '0);
    op(0, 10'h014, 0, '0);
    op(0, 10'h010, 0, '0);
    op(1, 10'h020, 32'hFFFF_FFFF, '0);
    op(0, 10'h020, 0, '0);
    op(1, 10'h010, 0, '0);
    // R3 carry from low into high half
    op(1, 10'h0F0, 32'hFFFF_FFFE, '0);
    op(1, 10'h0F4, 32'h0000_0001, '0);
    op(0, 10'h0F4, 0, '0);
    op(1, 10'h010, 32'h1, 3'b010);   // R10 arm channels 0 and 2
    idle(4);
    op(0, 10'h0F4, 0, '0);
    op(0, 10'h0F0, 0, '0);
    op(1, 10'h0F0, 32'h10, '0);      // R4 load while running
    op(1, 10'h010, 32'h1, 3'b000);   // R10 no edge: no arm
    op(1, 10'h010, 32'h0, '0);       // R2 freeze
    idle(3);
    op(0, 10'h0F0, 0, '0);
    op(1, 10'h010, 32'h3, 3'b111);   // R10 all at max: no arm
    idle(2);
    // R8/R9 channel window
    op(0, 10'h100, 0, '0);
    op(0, 10'h14C, 0, '0);
    op(1, 10'h150, 32'hDEAD_BEEF, '0);
    op(0, 10'h160, 0, '0);
    op(1, 10'h3FC, 32'h1, '0);
    op(0, 10'h030, 0, '0);
    // random mix
    pick = '{10'h000, 10'h004, 10'h010, 10'h014, 10'h020, 10'h0F0,
             10'h0F4, 10'h108, 10'h12C, 10'h150, 10'h170, 10'h0F0};
    for (int i = 0; i < 400; i++) begin
      logic [9:0] a;
      logic [31:0] d;
      bit wr;
      a  = ($urandom % 4 == 0) ? 10'($urandom) : pick[$urandom % 12];
      d  = $urandom;
      wr = ($urandom % 2) == 1;
      if (wr && {a[9:2], 2'b00} == 10'h0F4) d = d & 32'h0000_00FF;
      op(wr, a, d, NCH'($urandom));
      if ($urandom % 5 == 0) idle(1 + ($urandom % 3));
    end
    summary();
    $finish;
  end
endmodule